// File: doc/BRIEF.md
# Temperature Conversion Mode Sequencer

This block decides when an attached temperature converter is told to start, and what the 16-bit temperature register and the data-available flag show. After reset it is in continuous mode. It starts a conversion, waits for the converter's done pulse, stores the result, and starts the next conversion one idle cycle later. The data-available flag stays high throughout this mode.

Raising the power-down input does not cut off a conversion that is already running. That conversion completes and updates the register, and only then does the sequencer stop issuing starts. While powered down, a write strobe to the single-conversion bit launches exactly one conversion. Until that conversion returns, the register holds the 8000h placeholder and the data-available flag is low.

The converter always returns a 14-bit two's-complement sample. The sequencer places it left-justified in 16 bits. It then keeps only as many high bits as the resolution code latched at the start of that conversion allows. Each stored result is announced by a one-cycle valid pulse, which feeds a downstream limit comparator.

Top module: `tsense_conv_seq`

## Requirements
- R1: While reset is held, temp_reg reads 7FFCh and dav reads 1. After release, the first conv_start pulse comes on the first clock edge.
- R2: In continuous mode (pwr_down 0), a new conv_start pulse follows each stored result one cycle after result_valid. conv_start is never high for two cycles in a row.
- R3: A result is stored as {conv_result, 2'b00}, with the low bits cleared according to the word size: code 0 gives 11 bits (bits 15:5 kept), code 1 gives 12 bits (15:4), code 2 gives 13 bits (15:3) and code 3 gives 14 bits (15:2). Bits 1:0 are always 0.
- R4: The resolution code is sampled into conv_res when a conversion starts. A change to res_code during a conversion applies from the next conversion on.
- R5: If pwr_down rises while a conversion is running, that conversion still stores its result, and no further conv_start follows while pwr_down stays 1.
- R6: While powered down and idle, a oneshot_wr strobe issues one conv_start. temp_reg then reads 8000h and dav reads 0 until the result is stored. At that point dav returns to 1 and no further start follows.
- R7: A oneshot_wr strobe has no effect while pwr_down is 0, or while a conversion is still in flight. dav stays 1, temp_reg keeps the last result, and no extra start is issued.
- R8: result_valid is a one-cycle pulse in the cycle that temp_reg shows a newly stored result. It is only ever caused by a conv_done that arrives while a conversion is in flight.
- R9: Outside a pending single conversion, dav reads 1, and whenever dav is 0 temp_reg reads 8000h.
- R10: Clearing pwr_down while idle resumes continuous conversion with a conv_start on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down | input | 1 | Power-down (shutdown) mode bit |
| oneshot_wr | input | 1 | One-cycle strobe: 1 written to the single-conversion bit |
| res_code | input | 2 | Resolution code, 0 = 11 bits through 3 = 14 bits |
| conv_done | input | 1 | Converter done pulse |
| conv_result | input | 14 | Converter sample, two's complement |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_res | output | 2 | Resolution latched for the running conversion |
| temp_reg | output | 16 | Temperature register contents |
| dav | output | 1 | Data-available flag |
| result_valid | output | 1 | One-cycle pulse per stored result |

## Verification
The sequencer has no parameters, so the bench builds it as it stands. The bench's converter model takes CONV_BASE = 4 cycles for an 11-bit conversion and doubles that for each resolution step, giving 4, 8, 16 and 32 cycles. These short times keep the ratio of the real conversion times. They also let a single run cover all four word sizes, a resolution change in mid-conversion, a shutdown that waits for the running conversion, single conversions with their placeholder, and a long idle stretch after each of them.

// File: rtl/tsense_conv_seq.sv
module tsense_conv_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_down,
  input  logic        oneshot_wr,
  input  logic [1:0]  res_code,
  input  logic        conv_done,
  input  logic [13:0] conv_result,
  output logic        conv_start,
  output logic [1:0]  conv_res,
  output logic [15:0] temp_reg,
  output logic        dav,
  output logic        result_valid
);

  logic        busy;
  logic        os_pend;
  logic        go;
  logic        fin;
  logic [15:0] keep_mask;

  assign go        = !busy && (!pwr_down || oneshot_wr);
  assign fin       = busy && conv_done;
  assign keep_mask = 16'hFFFF << (3'd5 - {1'b0, conv_res});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      os_pend      <= 1'b0;
      conv_start   <= 1'b0;
      conv_res     <= 2'd0;
      temp_reg     <= 16'h7FFC;
      dav          <= 1'b1;
      result_valid <= 1'b0;
    end else begin
      conv_start   <= go;
      result_valid <= fin;
      if (go) begin
        busy     <= 1'b1;
        conv_res <= res_code;
        if (pwr_down) begin
          os_pend  <= 1'b1;
          dav      <= 1'b0;
          temp_reg <= 16'h8000;
        end
      end else if (fin) begin
        busy     <= 1'b0;
        temp_reg <= {conv_result, 2'b00} & keep_mask;
        if (os_pend) begin
          os_pend <= 1'b0;
          dav     <= 1'b1;
        end
      end
    end
  end

  // R2 R5 R7
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(!pwr_down || oneshot_wr));

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R3
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    temp_reg[1:0] == 2'b00);

  // R6 R9
  placeholder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dav |-> temp_reg == 16'h8000);

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  // R8
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(conv_done));

endmodule

// File: tb/tsense_conv_seq_tb.sv
module tsense_conv_seq_tb;
  localparam int CONV_BASE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_down = 1'b0;
  logic        oneshot_wr = 1'b0;
  logic [1:0]  res_code = 2'd0;
  logic        conv_done = 1'b0;
  logic [13:0] conv_result = 14'd0;
  logic        conv_start;
  logic [1:0]  conv_res;
  logic [15:0] temp_reg;
  logic        dav;
  logic        result_valid;

  logic [13:0] model_val = 14'h0320;
  int          cnt = 0;
  int          starts = 0;
  int          errors = 0;
  int          checks = 0;

  always #2.5 clk = ~clk;

  tsense_conv_seq u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .oneshot_wr(oneshot_wr),
    .res_code(res_code), .conv_done(conv_done), .conv_result(conv_result),
    .conv_start(conv_start), .conv_res(conv_res), .temp_reg(temp_reg),
    .dav(dav), .result_valid(result_valid)
  );

  always @(negedge clk) begin
    conv_done = 1'b0;
    if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) begin
        conv_done   = 1'b1;
        conv_result = model_val;
      end
    end
    if (conv_start) begin
      cnt    = CONV_BASE << conv_res;
      starts = starts + 1;
    end
  end

  function automatic logic [15:0] exp_fmt(input logic [13:0] v, input logic [1:0] r);
    logic signed [15:0] s;
    s = {{2{v[13]}}, v};
    s = s >>> (3 - r);
    return 16'(s << (5 - r));
  endfunction

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_result();
    int n = 0;
    tick();
    while (!result_valid && n < 2000) begin
      tick();
      n++;
    end
    if (!result_valid) chk(1'b0, "R8 result timeout", 0, 1);
  endtask

  task automatic t_reset();
    repeat (4) tick();
    chk(temp_reg == 16'h7FFC, "R1 reset temp", temp_reg, 16'h7FFC);
    chk(dav == 1'b1, "R1 reset dav", dav, 1);
    rst_n = 1'b1;
    tick();
    chk(starts == 1, "R1 first start", starts, 1);
    chk(temp_reg == 16'h7FFC, "R1 temp before result", temp_reg, 16'h7FFC);
  endtask

  task automatic t_first();
    wait_result();
    chk(temp_reg == 16'h0C80, "R3 first result", temp_reg, 16'h0C80);
    chk(dav == 1'b1, "R9 dav continuous", dav, 1);
    tick();
    chk(result_valid == 1'b0, "R8 one-cycle pulse", result_valid, 0);
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 3; i++) begin
      int s0;
      wait_result();
      s0 = starts;
      tick();
      chk(starts == s0 + 1, "R2 restart after result", starts, s0 + 1);
    end
  endtask

  task automatic t_res_all();
    logic [13:0] vals [2];
    vals[0] = 14'h3FFF;
    vals[1] = 14'h0321;
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < 2; k++) begin
        wait_result();
        res_code  = 2'(r);
        model_val = vals[k];
        wait_result();
        chk(temp_reg == exp_fmt(vals[k], 2'(r)), "R3 format", temp_reg, exp_fmt(vals[k], 2'(r)));
      end
    end
  endtask

  task automatic t_res_mid();
    wait_result();
    res_code = 2'd3;
    tick();
    res_code  = 2'd0;
    model_val = 14'h0321;
    chk(conv_res == 2'd3, "R4 latched code", conv_res, 3);
    wait_result();
    chk(temp_reg == 16'h0C84, "R4 old code used", temp_reg, 16'h0C84);
    wait_result();
    chk(temp_reg == 16'h0C80, "R4 new code used", temp_reg, 16'h0C80);
  endtask

  task automatic t_shutdown();
    int s0;
    wait_result();
    tick();
    tick();
    pwr_down   = 1'b1;
    model_val  = 14'h1000;
    oneshot_wr = 1'b1;
    tick();
    oneshot_wr = 1'b0;
    s0 = starts;
    wait_result();
    chk(temp_reg == 16'h4000, "R5 drained result", temp_reg, 16'h4000);
    chk(dav == 1'b1, "R5 dav after drain", dav, 1);
    repeat (200) tick();
    chk(starts == s0, "R5 R7 halted", starts, s0);
    chk(temp_reg == 16'h4000, "R5 temp held", temp_reg, 16'h4000);
  endtask

  task automatic t_oneshot();
    int s0;
    s0 = starts;
    model_val  = 14'h3E00;
    oneshot_wr = 1'b1;
    tick();
    oneshot_wr = 1'b0;
    chk(starts == s0 + 1, "R6 one start", starts, s0 + 1);
    chk(temp_reg == 16'h8000, "R6 placeholder", temp_reg, 16'h8000);
    chk(dav == 1'b0, "R6 dav low", dav, 0);
    tick();
    chk(dav == 1'b0, "R6 dav still low", dav, 0);
    wait_result();
    chk(temp_reg == 16'hF800, "R6 result", temp_reg, 16'hF800);
    chk(dav == 1'b1, "R6 dav back", dav, 1);
    repeat (100) tick();
    chk(starts == s0 + 1, "R6 single only", starts, s0 + 1);
  endtask

  task automatic t_resume();
    int s0;
    s0 = starts;
    pwr_down = 1'b0;
    tick();
    chk(starts == s0 + 1, "R10 resume", starts, s0 + 1);
    chk(dav == 1'b1, "R10 dav", dav, 1);
  endtask

  task automatic t_ignored();
    int s0;
    logic [15:0] last;
    wait_result();
    last = temp_reg;
    oneshot_wr = 1'b1;
    tick();
    oneshot_wr = 1'b0;
    chk(dav == 1'b1, "R7 dav unaffected", dav, 1);
    chk(temp_reg == last, "R7 temp unaffected", temp_reg, last);
    tick();
    oneshot_wr = 1'b1;
    tick();
    oneshot_wr = 1'b0;
    s0 = starts;
    wait_result();
    tick();
    chk(starts == s0 + 1, "R7 no extra start", starts, s0 + 1);
    chk(dav == 1'b1 && temp_reg != 16'h8000, "R7 no placeholder", temp_reg, last);
  endtask

  task automatic t_dav_cont();
    int bad = 0;
    for (int i = 0; i < 60; i++) begin
      tick();
      if (dav !== 1'b1) bad++;
    end
    chk(bad == 0, "R9 dav high window", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_first();
    t_back_to_back();
    t_res_all();
    t_res_mid();
    t_shutdown();
    t_oneshot();
    t_resume();
    t_ignored();
    t_dav_cont();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule